// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block collects completion and error events from a bank of DMA channels and presents them to software through a small register bus. Each channel has a completion flag, an error flag and an error-kind flag that says whether the error came from the bus or from a termination. The block also holds per-channel freeze, clock-gate-off and reset controls and the two burst enables. It reduces the flags to a single interrupt line and a priority-encoded "next event" indication.

Each register can be written in three ways. A plain write replaces its contents. A set write ORs the data in. A clear write removes the bits that are ones in the data. This lets software acknowledge one channel without a read-modify-write. A termination error that arrives together with a completion on the same channel does not count as an error. A bus error always counts. Every newly effective error resets its channel with a one-cycle pulse.

The channel count `NUM_CH` can be 2 to 8. The control register packs freeze, gate and reset fields eight bits apart.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, all three registers read 0, `irq` is low, `evtValid` is low and every control output is 0.
- R2: `addr[5:4]` selects the register: 0 is control, 1 is completion/enable and 2 is error. `addr[3:2]` selects the alias: 0 is plain write, 1 is set (OR), 2 is clear (AND-NOT), and 3 ignores the write. A read through any alias returns the register value.
- R3: In the control register, bit `ch` drives `chanFreeze[ch]` and bit `8+ch` drives `chanGateOff[ch]`. Bit 28 drives `burstEn` and bit 29 drives `burst8En`.
- R4: Writing a 1 to control bit `16+ch` raises `chanReset[ch]` for exactly one cycle after the write. The bit reads as 1 during that cycle and then clears itself.
- R5: A `cplPulse[ch]` sets completion bit `ch` (register 1). An `errPulse[ch]` sets error bit `ch` (register 2). If `errIsBus[ch]` is high at the same time, the pulse also sets bit `16+ch` (register 2). Bits `16+ch` of register 1 are the completion interrupt enables.
- R6: When an event pulse and a software clear of the same bit occur in one cycle, the bit ends up set.
- R7: A channel's effective error is set when its error bit and bus bit are both set. It is also set when its error bit is set, its bus bit is clear and its completion bit is clear.
- R8: `irq` is high exactly when some completion bit is set with its enable bit set, or some effective error is set.
- R9: The pending indication reports the highest set bit of the vector {effective errors, completion bits}, with errors above completions and channel `NUM_CH-1` above channel 0. Address 0x30 reads it as valid in bit 31, is-error in bit 8 and channel in bits 7:0. It reads 0 when nothing is pending.
- R10: When a channel's effective error goes from clear to set, `chanReset[ch]` pulses for one cycle, one cycle after the error becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Register and alias select |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 32 | Read data for `addr` |
| cplPulse | input | NUM_CH | Per-channel completion event |
| errPulse | input | NUM_CH | Per-channel error event |
| errIsBus | input | NUM_CH | Qualifies `errPulse` as a bus error |
| chanFreeze | output | NUM_CH | Per-channel freeze |
| chanGateOff | output | NUM_CH | Per-channel clock gate off |
| chanReset | output | NUM_CH | Per-channel reset pulse |
| burstEn | output | 1 | Burst enable |
| burst8En | output | 1 | 8-beat burst enable |
| irq | output | 1 | Combined interrupt |
| evtValid | output | 1 | An event is pending |
| evtIsErr | output | 1 | Pending event is an error |
| evtChan | output | CHW | Channel of pending event |

## Verification
The bench drives every completion/error/bus combination on every channel. It checks that a termination error masked by a completion raises neither `irq` nor a channel reset. A design that ignored that masking would reset healthy channels. The bench also races a clear-alias write against an incoming completion; if the clear won, an event would be lost. Priority is checked with errors and completions on several channels at once, then peeled off one by one with clear writes. A reversed encoder would service completions before errors. Finally, the bench checks that reset bits last exactly one cycle and that the ignored alias leaves the registers unchanged.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  typedef enum logic [1:0] {OP_PLAIN = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_NONE = 2'd3} aliasOpE;
  typedef enum logic [1:0] {SEL_CTRL = 2'd0, SEL_CPL = 2'd1, SEL_ERR = 2'd2, SEL_PEND = 2'd3} regSelE;

  typedef struct packed {
    logic        wrEn;
    regSelE      sel;
    aliasOpE     op;
    logic [31:0] data;
  } busStrobeT;

  function automatic logic [31:0] applyOp(logic [31:0] old, aliasOpE op, logic [31:0] data);
    case (op)
      OP_PLAIN: applyOp = data;
      OP_SET:   applyOp = old | data;
      OP_CLR:   applyOp = old & ~data;
      default:  applyOp = old;
    endcase
  endfunction
endpackage

// File: rtl/dma_irq_bus_ctrl.sv
module dma_irq_bus_ctrl
  import dma_irq_pkg::*;
(
  input  logic [5:0]  addr,
  input  logic [31:0] wdata,
  input  logic        we,
  output busStrobeT   strobe
);
  always_comb begin
    strobe.sel  = regSelE'(addr[5:4]);
    strobe.op   = aliasOpE'(addr[3:2]);
    strobe.data = wdata;
    strobe.wrEn = we && (addr[5:4] != 2'd3) && (addr[3:2] != 2'd3) && (addr[1:0] == 2'd0);
  end
endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobeT         strobe,
  input  logic [NUM_CH-1:0] cplPulse,
  input  logic [NUM_CH-1:0] errPulse,
  input  logic [NUM_CH-1:0] errIsBus,
  output logic [31:0]       rdata,
  output logic [NUM_CH-1:0] chanFreeze,
  output logic [NUM_CH-1:0] chanGateOff,
  output logic [NUM_CH-1:0] chanReset,
  output logic              burstEn,
  output logic              burst8En,
  output logic              irq,
  output logic              evtValid,
  output logic              evtIsErr,
  output logic [CHW-1:0]    evtChan
);
  localparam int HALF = 16;
  localparam int GATE_LSB = 8;
  localparam logic [31:0] CH_ONES = (32'd1 << NUM_CH) - 32'd1;
  localparam logic [31:0] MASK_CTRL = CH_ONES | (CH_ONES << GATE_LSB) | (32'd3 << 28);
  localparam logic [31:0] MASK_FLAG = CH_ONES | (CH_ONES << HALF);

  logic [31:0] ctrlQ, cplQ, errQ;
  logic [31:0] ctrlNext, cplNext, errNext, rstWord;
  logic [NUM_CH-1:0] rstQ, rstNext, effErr, effErrQ, cplVec, enVec, errVec, busVec;
  logic wrCtrl, wrCpl, wrErr;
  logic [2*NUM_CH-1:0] evtVec;
  logic [31:0] evtWord, busSet;

  always_comb begin
    wrCtrl = strobe.wrEn && (strobe.sel == SEL_CTRL);
    wrCpl  = strobe.wrEn && (strobe.sel == SEL_CPL);
    wrErr  = strobe.wrEn && (strobe.sel == SEL_ERR);

    ctrlNext = wrCtrl ? (applyOp(ctrlQ, strobe.op, strobe.data) & MASK_CTRL) : ctrlQ;
    rstWord  = wrCtrl ? applyOp(32'd0, strobe.op, strobe.data) : 32'd0;

    busSet  = 32'(errPulse & errIsBus) << HALF;
    cplNext = (wrCpl ? (applyOp(cplQ, strobe.op, strobe.data) & MASK_FLAG) : cplQ)
              | 32'(cplPulse);
    errNext = (wrErr ? (applyOp(errQ, strobe.op, strobe.data) & MASK_FLAG) : errQ)
              | 32'(errPulse) | busSet;

    cplVec = cplQ[NUM_CH-1:0];
    enVec  = cplQ[HALF +: NUM_CH];
    errVec = errQ[NUM_CH-1:0];
    busVec = errQ[HALF +: NUM_CH];
    effErr = (errVec & busVec) | (errVec & ~busVec & ~cplVec);

    rstNext = rstWord[HALF +: NUM_CH] | (effErr & ~effErrQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      cplQ    <= '0;
      errQ    <= '0;
      rstQ    <= '0;
      effErrQ <= '0;
    end else begin
      ctrlQ   <= ctrlNext;
      cplQ    <= cplNext;
      errQ    <= errNext;
      rstQ    <= rstNext;
      effErrQ <= effErr;
    end
  end

  // priority encoder: highest index of {errors, completions} wins
  always_comb begin
    evtVec   = {effErr, cplVec};
    evtValid = 1'b0;
    evtIsErr = 1'b0;
    evtChan  = '0;
    for (int i = 0; i < 2 * NUM_CH; i++) begin
      if (evtVec[i]) begin
        evtValid = 1'b1;
        evtIsErr = (i >= NUM_CH);
        evtChan  = CHW'(i % NUM_CH);
      end
    end
    evtWord = {evtValid, 22'd0, evtIsErr, 8'(evtChan)};
  end

  always_comb begin
    case (strobe.sel)
      SEL_CTRL: rdata = ctrlQ | (32'(rstQ) << HALF);
      SEL_CPL:  rdata = cplQ;
      SEL_ERR:  rdata = errQ;
      default:  rdata = evtWord;
    endcase
  end

  assign chanFreeze  = ctrlQ[NUM_CH-1:0];
  assign chanGateOff = ctrlQ[GATE_LSB +: NUM_CH];
  assign burstEn     = ctrlQ[28];
  assign burst8En    = ctrlQ[29];
  assign chanReset   = rstQ;
  assign irq         = (|(cplVec & enVec)) | (|effErr);

  // R6: an incoming completion is never lost, even against a clear
  p_cpl_event_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|cplPulse) |=> ((cplQ[NUM_CH-1:0] & $past(cplPulse)) == $past(cplPulse)));

  // R6 / R5: an incoming error is never lost
  p_err_event_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|errPulse) |=> ((errQ[NUM_CH-1:0] & $past(errPulse)) == $past(errPulse)));

  // R8: any effective error raises the interrupt
  p_err_raises_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|effErr) |-> irq);

  // R9: the reported event points at a set bit
  p_enc_points_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtIsErr ? effErr[evtChan] : cplVec[evtChan]));

  // R10: a newly effective error resets its channel on the next cycle
  p_auto_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((effErr & ~effErrQ) != '0) |=>
      ((rstQ & $past(effErr & ~effErrQ)) == $past(effErr & ~effErrQ)));
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  output logic [31:0]       rdata,
  input  logic [NUM_CH-1:0] cplPulse,
  input  logic [NUM_CH-1:0] errPulse,
  input  logic [NUM_CH-1:0] errIsBus,
  output logic [NUM_CH-1:0] chanFreeze,
  output logic [NUM_CH-1:0] chanGateOff,
  output logic [NUM_CH-1:0] chanReset,
  output logic              burstEn,
  output logic              burst8En,
  output logic              irq,
  output logic              evtValid,
  output logic              evtIsErr,
  output logic [CHW-1:0]    evtChan
);
  busStrobeT strobe;

  dma_irq_bus_ctrl u_ctrl (
    .addr   (addr),
    .wdata  (wdata),
    .we     (we),
    .strobe (strobe)
  );

  dma_irq_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cplPulse    (cplPulse),
    .errPulse    (errPulse),
    .errIsBus    (errIsBus),
    .rdata       (rdata),
    .chanFreeze  (chanFreeze),
    .chanGateOff (chanGateOff),
    .chanReset   (chanReset),
    .burstEn     (burstEn),
    .burst8En    (burst8En),
    .irq         (irq),
    .evtValid    (evtValid),
    .evtIsErr    (evtIsErr),
    .evtChan     (evtChan)
  );
endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we = 1'b0;
  logic [31:0] rdata;
  logic [N-1:0] cplPulse = '0, errPulse = '0, errIsBus = '0;
  logic [N-1:0] chanFreeze, chanGateOff, chanReset;
  logic burstEn, burst8En, irq, evtValid, evtIsErr;
  logic [2:0] evtChan;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_irq_status #(.NUM_CH(N)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .cplPulse(cplPulse), .errPulse(errPulse), .errIsBus(errIsBus),
    .chanFreeze(chanFreeze), .chanGateOff(chanGateOff), .chanReset(chanReset),
    .burstEn(burstEn), .burst8En(burst8En), .irq(irq),
    .evtValid(evtValid), .evtIsErr(evtIsErr), .evtChan(evtChan)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] pend(input logic v, input logic e, input int ch);
    return v ? {1'b1, 22'd0, e, 8'(ch)} : 32'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(6'h00, v); chk("R1 ctrl", v, 0);
    rd(6'h10, v); chk("R1 cpl", v, 0);
    rd(6'h20, v); chk("R1 err", v, 0);
    chk("R1 irq/evt", {irq, evtValid, chanReset, chanFreeze}, 0);

    // R3 control layout, R2 aliases
    wr(6'h00, 32'h3000_A55A);
    chk("R3 freeze", chanFreeze, 8'h5A);
    chk("R3 gate", chanGateOff, 8'hA5);
    chk("R3 burst", {burstEn, burst8En}, 2'b11);
    wr(6'h04, 32'h0000_0001);
    chk("R2 set alias", chanFreeze, 8'h5B);
    wr(6'h08, 32'h1000_0100);
    rd(6'h00, v); chk("R2 clear alias", v, 32'h2000_A45B);
    rd(6'h04, v); chk("R2 read set alias", v, 32'h2000_A45B);
    rd(6'h08, v); chk("R2 read clear alias", v, 32'h2000_A45B);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h00, v); chk("R2 ignored alias", v, 32'h2000_A45B);
    wr(6'h00, 32'h0);

    // R4 self-clearing reset
    wr(6'h04, 32'h0008_0000);
    chk("R4 pulse", chanReset, 8'h08);
    rd(6'h00, v); chk("R4 readback", v, 32'h0008_0000);
    @(negedge clk);
    chk("R4 cleared", chanReset, 8'h00);
    rd(6'h00, v); chk("R4 readback cleared", v, 0);

    // R5 R7 R8 R9 R10 sweep of every event mix on every channel
    for (int ch = 0; ch < N; ch++) begin
      for (int k = 0; k < 8; k++) begin
        logic c, e, b, eff;
        c = k[0]; e = k[1]; b = k[2];
        eff = e && (b || !c);
        @(negedge clk);
        cplPulse[ch] = c; errPulse[ch] = e; errIsBus[ch] = b;
        @(negedge clk);
        cplPulse = '0; errPulse = '0; errIsBus = '0;
        rd(6'h10, v); chk("R5 cpl flag", v, 32'(c) << ch);
        rd(6'h20, v); chk("R5 err flags", v, (32'(e) << ch) | (32'(e & b) << (16 + ch)));
        chk("R7 R8 irq", irq, eff);
        rd(6'h30, v); chk("R9 pending", v, pend(eff | c, eff, ch));
        chk("R10 no early reset", chanReset, 0);
        @(negedge clk);
        chk("R10 auto reset", chanReset, 8'(eff) << ch);
        wr(6'h20, 32'h0);
        wr(6'h10, 32'h0);
      end
    end

    // R8 enable gating
    wr(6'h14, 32'h0004_0000);
    @(negedge clk); cplPulse[2] = 1'b1;
    @(negedge clk); cplPulse = '0;
    chk("R8 enabled irq", irq, 1);
    wr(6'h18, 32'h0004_0000);
    chk("R8 disabled irq", irq, 0);

    // R9 priority across channels
    @(negedge clk);
    cplPulse = 8'h24; errPulse = 8'h02; errIsBus = 8'h02;
    @(negedge clk);
    cplPulse = '0; errPulse = '0; errIsBus = '0;
    rd(6'h30, v); chk("R9 error first", v, pend(1, 1, 1));
    wr(6'h28, 32'h0002_0002);
    rd(6'h30, v); chk("R9 highest completion", v, pend(1, 0, 5));
    wr(6'h18, 32'h0000_0020);
    rd(6'h30, v); chk("R9 next completion", v, pend(1, 0, 2));

    // R6 event beats a simultaneous clear
    @(negedge clk);
    addr = 6'h18; wdata = 32'hFFFF_FFFF; we = 1'b1; cplPulse[3] = 1'b1;
    @(negedge clk);
    we = 1'b0; cplPulse = '0;
    rd(6'h10, v); chk("R6 event wins", v, 32'h0000_0008);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule